// File: doc/BRIEF.md
# Six-Channel PWM Generator with Triggered Settings Update

This block produces six independent pulse-width-modulated outputs. A small synchronous register bus gives software access to one control word, one packed prescale word and a pair of 24-bit count words for each channel. Writes to the prescale, period, high-time and polarity fields go into holding (shadow) storage only. A channel's running waveform picks up the held values when software raises that channel's trigger bit.

The smooth bit, sampled when the trigger rises, selects how the update is applied. With smooth clear, the new values load one cycle after the edge is seen and the prescale and period counters restart from zero. With smooth set, the old waveform keeps running until its current period ends, and the new values load on that period boundary. There is no enable bit. A channel whose trigger and smooth bits are both clear drives a constant high level. Loading a high-time count of zero gives a steady inactive level.

Each period lasts (prescale+1)·period clocks. The output sits at its active level for the first (prescale+1)·high-time clocks of the period. Polarity 1 makes the active level high. The output-type bit of each channel is held and can be read back, but it has no effect on the logic.

Top module: `trigpwm_ctrl`

## Requirements
- R1: After reset every register reads 0 and every output is high.
- R2: Register map, on byte addresses:
  - 0x0 is the control word. For channel c it holds trigger at bit c, polarity at bit 8+c, output type at bit 16+c and smooth at bit 24+c.
  - 0x4 holds a 3-bit prescale for channel c at bits 4c+2..4c.
  - 0x8+8c holds the 24-bit period of channel c, and 0xC+8c holds its 24-bit high time.
  - Unused bits and unmapped addresses read 0.
  - Read data is valid in the cycle after the read request and is 0 in every other cycle.
- R3: While a channel's trigger and smooth bits are both 0, its output is high, whatever its other settings.
- R4: Writes to prescale, period, high time or polarity do not change a running output until that channel's trigger bit next goes from 0 to 1.
- R5: When the trigger rises with smooth 0, the new settings take effect on the clock edge after the control write. At that edge the counters restart at period position 0, so the output is at its active level there when the high time is nonzero.
- R6: When the trigger rises with smooth 1, the old waveform continues to the end of its current period. The new settings load exactly on the boundary that ends it.
- R7: A period lasts (prescale+1)·period clocks, of which (prescale+1)·high-time are at the active level.
- R8: Polarity 1 makes the active level high. Polarity 0 makes it low.
- R9: A high time of 0 gives a constant inactive level. A high time greater than or equal to the period gives a constant active level.
- R10: Channels are independent: settings and triggers on one channel do not change the output of any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| pwm_o | output | NCH (6) | Channel outputs |

## Verification
Read data appears one edge after the request, so the bench samples it on the falling edge after the request edge. An immediate update shows at the output on the second edge counted from the control write's own edge. The bench therefore takes its first sample on the falling edge after that second edge and checks the active level there. Duty checks count high samples over a window exactly one period long, so the result does not depend on where the window starts in the period. For the boundary update, the bench issues back-to-back writes with known period positions. It then expects exactly seven old-level samples before the first new-level sample.

// File: rtl/trigpwm_pkg.sv
package trigpwm_pkg;
  localparam int DATA_W        = 32;
  localparam int CNT_W         = 24;
  localparam int PRE_W         = 3;
  // control word field bases, one bit per channel in each byte
  localparam int TRIG_LSB      = 0;
  localparam int POL_LSB       = 8;
  localparam int TYPE_LSB      = 16;
  localparam int SMOOTH_LSB    = 24;
  localparam int PRE_STRIDE    = 4;
  // word addresses
  localparam int CTRL_WORD     = 0;
  localparam int PRE_WORD      = 1;
  localparam int CNT_BASE_WORD = 2;

  typedef struct packed {
    logic             pol;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] duty;
  } chan_cfg_t;
endpackage

// File: rtl/trigpwm_rst_sync.sv
module trigpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/trigpwm_regs.sv
module trigpwm_regs
  import trigpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    trig_o,
  output logic [NCH-1:0]    smooth_o,
  output chan_cfg_t         cfg_o [NCH]
);
  localparam int WA_W = AW - 2;

  logic [WA_W-1:0]  wa;
  logic             wr, rd;
  logic [NCH-1:0]   trig_q, trig_d, pol_q, pol_d, otype_q, otype_d, smooth_q, smooth_d;
  logic [PRE_W-1:0] pre_q [NCH];
  logic [PRE_W-1:0] pre_d [NCH];
  logic [CNT_W-1:0] per_q [NCH];
  logic [CNT_W-1:0] per_d [NCH];
  logic [CNT_W-1:0] duty_q [NCH];
  logic [CNT_W-1:0] duty_d [NCH];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic unused_bits;

  assign wa = addr[AW-1:2];
  assign wr = sel & we;
  assign rd = sel & ~we;
  assign unused_bits = ^{addr[1:0], wdata};

  always_comb begin
    trig_d   = trig_q;
    pol_d    = pol_q;
    otype_d  = otype_q;
    smooth_d = smooth_q;
    pre_d    = pre_q;
    per_d    = per_q;
    duty_d   = duty_q;
    rdata_d  = '0;
    if (wr && wa == WA_W'(CTRL_WORD)) begin
      trig_d   = wdata[TRIG_LSB   +: NCH];
      pol_d    = wdata[POL_LSB    +: NCH];
      otype_d  = wdata[TYPE_LSB   +: NCH];
      smooth_d = wdata[SMOOTH_LSB +: NCH];
    end
    for (int c = 0; c < NCH; c++) begin
      if (wr && wa == WA_W'(PRE_WORD))
        pre_d[c] = wdata[PRE_STRIDE*c +: PRE_W];
      if (wr && wa == WA_W'(CNT_BASE_WORD + 2*c))
        per_d[c] = wdata[CNT_W-1:0];
      if (wr && wa == WA_W'(CNT_BASE_WORD + 2*c + 1))
        duty_d[c] = wdata[CNT_W-1:0];
    end
    if (rd) begin
      if (wa == WA_W'(CTRL_WORD)) begin
        rdata_d[TRIG_LSB   +: NCH] = trig_q;
        rdata_d[POL_LSB    +: NCH] = pol_q;
        rdata_d[TYPE_LSB   +: NCH] = otype_q;
        rdata_d[SMOOTH_LSB +: NCH] = smooth_q;
      end
      for (int c = 0; c < NCH; c++) begin
        if (wa == WA_W'(PRE_WORD))
          rdata_d[PRE_STRIDE*c +: PRE_W] = pre_q[c];
        if (wa == WA_W'(CNT_BASE_WORD + 2*c))
          rdata_d = DATA_W'(per_q[c]);
        if (wa == WA_W'(CNT_BASE_WORD + 2*c + 1))
          rdata_d = DATA_W'(duty_q[c]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= '0;
      pol_q    <= '0;
      otype_q  <= '0;
      smooth_q <= '0;
      rdata_q  <= '0;
      for (int c = 0; c < NCH; c++) begin
        pre_q[c]  <= '0;
        per_q[c]  <= '0;
        duty_q[c] <= '0;
      end
    end else begin
      trig_q   <= trig_d;
      pol_q    <= pol_d;
      otype_q  <= otype_d;
      smooth_q <= smooth_d;
      rdata_q  <= rdata_d;
      pre_q    <= pre_d;
      per_q    <= per_d;
      duty_q   <= duty_d;
    end
  end

  assign rdata    = rdata_q;
  assign trig_o   = trig_q;
  assign smooth_o = smooth_q;

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg_o[c] = '{pol: pol_q[c], pre: pre_q[c], per: per_q[c], duty: duty_q[c]};
  end
endmodule

// File: rtl/trigpwm_chan.sv
module trigpwm_chan
  import trigpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig,
  input  logic      smooth,
  input  chan_cfg_t cfg,
  output logic      pwm_o,
  output logic      load_o,
  output logic      pend_o
);
  logic             trig_q, pend_q, pend_d, out_q, out_d;
  chan_cfg_t        act_q, act_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [CNT_W-1:0] per_cnt_q, per_cnt_d;
  logic rise, imm, arm, deferred, load, pre_wrap, per_last, boundary, lvl;

  always_comb begin
    rise     = trig & ~trig_q;
    imm      = rise & ~smooth;
    arm      = rise & smooth;
    pre_wrap = (pre_cnt_q == act_q.pre);
    per_last = ((CNT_W+1)'(per_cnt_q) + (CNT_W+1)'(1)) >= (CNT_W+1)'(act_q.per);
    boundary = pre_wrap & per_last;
    deferred = (pend_q | arm) & boundary & ~imm;
    load     = imm | deferred;
    pend_d   = load ? 1'b0 : (pend_q | arm);
    act_d    = load ? cfg : act_q;
    if (imm) begin
      pre_cnt_d = '0;
      per_cnt_d = '0;
    end else begin
      pre_cnt_d = pre_wrap ? '0 : pre_cnt_q + PRE_W'(1);
      per_cnt_d = pre_wrap ? (per_last ? '0 : per_cnt_q + CNT_W'(1)) : per_cnt_q;
    end
    lvl   = (per_cnt_d < act_d.duty);
    out_d = (~smooth & ~trig) ? 1'b1 : (act_d.pol ? lvl : ~lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      pend_q    <= 1'b0;
      act_q     <= '0;
      pre_cnt_q <= '0;
      per_cnt_q <= '0;
      out_q     <= 1'b1;
    end else begin
      trig_q    <= trig;
      pend_q    <= pend_d;
      act_q     <= act_d;
      pre_cnt_q <= pre_cnt_d;
      per_cnt_q <= per_cnt_d;
      out_q     <= out_d;
    end
  end

  assign pwm_o  = out_q;
  assign load_o = load;
  assign pend_o = pend_q;
endmodule

// File: rtl/trigpwm_ctrl.sv
module trigpwm_ctrl
  import trigpwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  logic           rst_sync_n;
  logic [NCH-1:0] trig_v, smooth_v, load_v, pend_v;
  chan_cfg_t      cfg_v [NCH];

  trigpwm_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  trigpwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .trig_o(trig_v), .smooth_o(smooth_v), .cfg_o(cfg_v)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trigpwm_chan u_chan (
      .clk(clk), .rst_n(rst_sync_n), .trig(trig_v[c]), .smooth(smooth_v[c]),
      .cfg(cfg_v[c]), .pwm_o(pwm_o[c]), .load_o(load_v[c]), .pend_o(pend_v[c])
    );
  end
endmodule

// File: rtl/trigpwm_chk.sv
module trigpwm_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_we,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] trig,
  input logic [NCH-1:0] smooth,
  input logic [NCH-1:0] pwm_o,
  input logic [NCH-1:0] load_v,
  input logic [NCH-1:0] pend_v
);
  // R2: read data is zero except in the cycle after a read request
  p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> (bus_rdata == 32'd0));

  for (genvar c = 0; c < NCH; c++) begin : g_p
    // R3: idle control state forces the output high
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!smooth[c] && !trig[c]) |=> pwm_o[c]);
    // R4: active settings load only with the trigger high or an update pending
    p_load_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_v[c] |-> (trig[c] || pend_v[c]));
    // R6: a pending boundary update ends only by loading
    p_pend_to_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_v[c]) |-> $past(load_v[c]));
  end
endmodule

bind trigpwm_ctrl trigpwm_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .trig(trig_v), .smooth(smooth_v), .pwm_o(pwm_o),
  .load_v(load_v), .pend_v(pend_v)
);

// File: tb/trigpwm_ctrl_tb.sv
module trigpwm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  pwm_o;
  int n_run = 0, n_fail = 0;
  logic [31:0] ctrl_sh = '0, pre_sh = '0;

  always #5 clk = ~clk;

  trigpwm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
    end
  endtask

  task automatic set_ctrl(input int ch, input bit trg, input bit pol, input bit smo);
    ctrl_sh[ch] = trg; ctrl_sh[8+ch] = pol; ctrl_sh[24+ch] = smo;
    wr(8'h00, ctrl_sh);
  endtask

  // hold old waveform, load shadows, immediate trigger
  task automatic apply(input int ch, input int pre, input int per, input int duty, input bit pol);
    set_ctrl(ch, 1'b0, ctrl_sh[8+ch], 1'b1);
    pre_sh[4*ch +: 3] = pre[2:0];
    wr(8'h04, pre_sh);
    wr(8'(8 + 8*ch), 32'(per));
    wr(8'(12 + 8*ch), 32'(duty));
    set_ctrl(ch, 1'b1, pol, 1'b0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs", 32'(pwm_o), 32'h3F);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 prescale", d, 0);
    rd(8'h08, d); chk("R1 period0", d, 0);
    rd(8'h34, d); chk("R1 duty5", d, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(8'h00, 32'hFFEA95C0);
    rd(8'h00, d); chk("R2 ctrl fields", d, 32'h3F2A1500);
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h04, d); chk("R2 prescale fields", d, 32'h00777777);
    wr(8'h30, 32'hFFFFFFFF);
    rd(8'h30, d); chk("R2 period5 width", d, 32'h00FFFFFF);
    wr(8'h1C, 32'h00ABCDEF);
    rd(8'h1C, d); chk("R2 duty2", d, 32'h00ABCDEF);
    rd(8'h40, d); chk("R2 unmapped", d, 0);
    @(negedge clk); chk("R2 rdata returns to 0", bus_rdata, 0);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h30, 32'h0); wr(8'h1C, 32'h0);
  endtask

  task automatic t_idle;
    int hi;
    wr(8'h08, 32'd4); wr(8'h0C, 32'd1);
    set_ctrl(0, 1'b0, 1'b1, 1'b0);
    count_hi(0, 8, hi); chk("R3 idle output high", 32'(hi), 8);
  endtask

  task automatic t_immediate;
    int hi;
    set_ctrl(0, 1'b1, 1'b1, 1'b0);
    @(negedge clk); chk("R5 active at restart", 32'(pwm_o[0]), 1);
    count_hi(0, 3, hi); chk("R5 rest of first period low", 32'(hi), 0);
    count_hi(0, 4, hi); chk("R7 duty 1 of 4", 32'(hi), 1);
  endtask

  task automatic t_formula;
    int hi;
    apply(0, 2, 5, 2, 1'b1);
    count_hi(0, 15, hi); chk("R7 prescaled 6 of 15", 32'(hi), 6);
  endtask

  task automatic t_shadow;
    int hi;
    wr(8'h0C, 32'd3);
    wr(8'h04, 32'h0);
    set_ctrl(0, 1'b1, 1'b0, 1'b0);
    count_hi(0, 15, hi); chk("R4 shadow writes ignored", 32'(hi), 6);
    pre_sh = 32'h0; wr(8'h04, 32'h2); pre_sh = 32'h2;
    ctrl_sh[8] = 1'b1; wr(8'h00, ctrl_sh);
  endtask

  task automatic t_polarity;
    int hi;
    apply(0, 2, 5, 2, 1'b0);
    count_hi(0, 15, hi); chk("R8 inverted 9 of 15", 32'(hi), 9);
  endtask

  task automatic t_extremes;
    int hi;
    apply(0, 0, 5, 0, 1'b1);
    count_hi(0, 10, hi); chk("R9 zero duty inactive", 32'(hi), 0);
    apply(0, 0, 5, 7, 1'b1);
    count_hi(0, 10, hi); chk("R9 duty over period active", 32'(hi), 10);
  endtask

  task automatic t_smooth;
    int first, hi;
    wr(8'h10, 32'd10);
    wr(8'h14, 32'd0);
    set_ctrl(1, 1'b1, 1'b1, 1'b0);   // immediate: steady low, position 0 at next edge
    wr(8'h14, 32'd10);               // shadow high time = period
    set_ctrl(1, 1'b0, 1'b1, 1'b1);   // hold
    set_ctrl(1, 1'b1, 1'b1, 1'b1);   // boundary trigger
    first = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (first == 0 && pwm_o[1]) first = i;
    end
    chk("R6 first new-level sample", 32'(first), 8);
    count_hi(1, 10, hi); chk("R6 new settings held", 32'(hi), 10);
  endtask

  task automatic t_indep;
    int hi;
    count_hi(0, 10, hi); chk("R10 channel 0 unchanged", 32'(hi), 10);
    chk("R10 idle channels high", 32'(pwm_o[5:2]), 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regmap;
    t_idle;
    t_immediate;
    t_formula;
    t_shadow;
    t_polarity;
    t_extremes;
    t_smooth;
    t_indep;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule